// File: doc/BRIEF.md
# Serial SAR Converter Frame Reader

This block runs from a fast system clock and reads a 14-bit successive-approximation converter over a three-wire serial link. The three wires are an active-low chip select, a serial clock, and one serial data line that the converter drives. The serial clock comes from a programmable half-period divider. Each frame begins when chip select falls while the serial clock is low. The reader samples one bit on every rising edge of the serial clock. It drops the two leading zeros the converter sends first and shifts in the result, most significant bit first. When chip select rises, it presents the result in parallel with a one-cycle strobe.

The converter launches each bit on a falling edge of the serial clock. The fall of chip select counts as the first of these falling edges. A full frame has eighteen serial clock periods. The reader can also short-cycle a frame: it raises chip select as soon as the last wanted result bit has been captured, and the bits it did not read come out as zeros below the ones it did.

After every frame a programmable idle gap runs in system clock cycles. A new frame cannot start until the gap has run out. The gap therefore sets the sample rate and guarantees the converter its acquisition time. The divider setting and the bit count are taken when a frame starts and stay fixed for the rest of that frame.

Top module: `sar_frame_reader`

## Requirements
- R1: While reset is held and after it is released, `cs_n` is 1, `sclk` is 0, `busy` is 0, `result_valid` is 0 and `result` is 0.
- R2: A `start` seen on a clock edge begins a frame only if no frame is in progress and the idle gap has run out. A `start` seen at any other time is ignored.
- R3: Chip select falls while `sclk` is low. The first rising edge of `sclk` comes H system cycles later, and `sclk` then has a period of 2H cycles. H is `half_div`, and a value of 0 is treated as 1.
- R4: The reader samples `sdi` on each rising edge of `sclk`. Rising edges 1 and 2 carry the leading zeros and are discarded. Rising edges 3 to 16 carry result bits 13 down to 0 in that order.
- R5: A full frame has 18 rising edges. It is used when `bit_count` is 14, 0, or greater than 14. Chip select rises in the same cycle in which `sclk` falls after the 18th high phase, so chip select is low for 36H cycles.
- R6: A short frame is used when `bit_count` is N in 1..13. Chip select rises at the end of the high phase of rising edge N+2, so chip select is low for 2H(N+2) cycles.
- R7: In a short frame, the N bits received fill `result[13:14-N]` and the lower bits are 0.
- R8: `result_valid` is high for exactly one cycle, the cycle in which `cs_n` rises, and `result` holds the value of that frame from then on.
- R9: After chip select rises, the next frame can start no sooner than `gap_cycles` cycles later, and chip select stays high for at least one cycle.
- R10: `busy` is high exactly while `cs_n` is low.
- R11: `sclk` stays low whenever `cs_n` is high.
- R12: Changes to `half_div` and `bit_count` while a frame is running do not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Frame request |
| half_div | input | 8 | Serial clock half period in system cycles |
| bit_count | input | 4 | Result bits wanted (1..14; 0 or >14 means 14) |
| gap_cycles | input | 16 | Minimum idle cycles between frames |
| sdi | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock |
| result | output | 14 | Left-aligned conversion result |
| result_valid | output | 1 | One-cycle result strobe |
| busy | output | 1 | Frame in progress |

## Verification
The bench models the converter and drives `sdi` from the `cs_n` and `sclk` edges it observes.

- **Data words.** Frames carry several words: alternating bits, all ones, a lone MSB and a lone LSB. These show whether the leading zeros are dropped, whether the bit order is right, and whether the capture window is off by one edge.
- **Divider settings.** The divider is run at 1, 2 and 3, including 0 treated as 1. These settings tell a correct edge schedule from a half-period counting error.
- **Bit counts.** Full frames and short frames of 1 and 5 bits separate the end-of-frame edge choice from the left alignment.
- **Held start and mid-frame changes.** A `start` held through a frame and its gap checks that early requests are ignored and that the gap length is exact. Changing the divider and the bit count in the middle of a frame shows whether the configuration was latched at the start.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HIGH,
    ST_LOW
  } rd_state_e;

  // zero bits the converter sends ahead of the result
  localparam int LEAD_ZEROS = 2;
  // serial clock periods beyond the result bits in a full frame
  localparam int TAIL_EDGES = 2;

endpackage

// File: rtl/sar_rd_phase.sv
module sar_rd_phase #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [DIV_W-1:0] limit,
  output logic             last
);

  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign last = run && (cnt_q == limit - DIV_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr || last) begin
      cnt_d = '0;
    end else if (run) begin
      cnt_d = cnt_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/sar_rd_shift.sv
module sar_rd_shift #(
  parameter int RES_W  = 14,
  parameter int BCNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              cap_en,
  input  logic              sdi,
  input  logic [BCNT_W-1:0] nbits,
  input  logic              publish,
  output logic [RES_W-1:0]  result
);

  logic [RES_W-1:0]  shreg_q, shreg_d;
  logic [RES_W-1:0]  res_q, res_d;
  logic [BCNT_W-1:0] shamt;

  assign shamt = BCNT_W'(RES_W) - nbits;

  always_comb begin
    shreg_d = shreg_q;
    if (clr) begin
      shreg_d = '0;
    end else if (cap_en) begin
      shreg_d = {shreg_q[RES_W-2:0], sdi};
    end
  end

  always_comb begin
    res_d = res_q;
    if (publish) begin
      res_d = shreg_q << shamt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      res_q   <= '0;
    end else begin
      shreg_q <= shreg_d;
      res_q   <= res_d;
    end
  end

  assign result = res_q;

  AST_NO_CAPTURE_ON_PUBLISH: assert property (@(posedge clk) disable iff (!rst_n)
    publish |-> !cap_en); // R4

endmodule

// File: rtl/sar_rd_gap.sv
module sar_rd_gap #(
  parameter int GAP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [GAP_W-1:0] gap_in,
  output logic             ready
);

  logic [GAP_W-1:0] cnt_q, cnt_d;

  assign ready = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = gap_in;
    end else if (!ready) begin
      cnt_d = cnt_q - GAP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/sar_frame_reader.sv
module sar_frame_reader
  import sar_rd_pkg::*;
#(
  parameter  int RES_W  = 14,
  parameter  int DIV_W  = 8,
  parameter  int GAP_W  = 16,
  localparam int BCNT_W = $clog2(RES_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DIV_W-1:0]  half_div,
  input  logic [BCNT_W-1:0] bit_count,
  input  logic [GAP_W-1:0]  gap_cycles,
  input  logic              sdi,
  output logic              cs_n,
  output logic              sclk,
  output logic [RES_W-1:0]  result,
  output logic              result_valid,
  output logic              busy
);

  localparam int FRAME_EDGES = RES_W + LEAD_ZEROS + TAIL_EDGES;
  localparam int EDGE_W      = $clog2(FRAME_EDGES + 1);
  localparam logic [EDGE_W-1:0] LEAD_E = EDGE_W'(LEAD_ZEROS);
  localparam logic [EDGE_W-1:0] FULL_E = EDGE_W'(FRAME_EDGES);

  // reset: asynchronous assertion, synchronous release
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end
  logic rst_i_n;
  assign rst_i_n = rst_sync_q;

  rd_state_e state_q, state_d;
  logic              cs_n_q, cs_n_d;
  logic              sclk_q, sclk_d;
  logic              valid_q, valid_d;
  logic [EDGE_W-1:0] edge_q, edge_d;
  logic [DIV_W-1:0]  half_q, half_d;
  logic [BCNT_W-1:0] nbits_q, nbits_d;
  logic [EDGE_W-1:0] end_q, end_d;

  // configuration decode (sampled only on frame start)
  logic [DIV_W-1:0]  half_eff;
  logic [BCNT_W-1:0] nbits_eff;
  logic [EDGE_W-1:0] end_eff;

  always_comb begin
    half_eff  = (half_div == '0) ? DIV_W'(1) : half_div;
    nbits_eff = ((bit_count == '0) || (bit_count > BCNT_W'(RES_W))) ?
                BCNT_W'(RES_W) : bit_count;
    end_eff   = (nbits_eff == BCNT_W'(RES_W)) ? FULL_E :
                EDGE_W'(nbits_eff) + LEAD_E;
  end

  logic ph_last, gap_ready, accept;
  logic cap_en, publish, frame_clr, gap_load;
  logic [EDGE_W-1:0] edge_nx;

  assign accept  = (state_q == ST_IDLE) && start && gap_ready;
  assign edge_nx = (state_q == ST_SETUP) ? EDGE_W'(1) : edge_q + EDGE_W'(1);

  sar_rd_phase #(.DIV_W(DIV_W)) u_phase (
    .clk   (clk),
    .rst_n (rst_i_n),
    .run   (state_q != ST_IDLE),
    .clr   (accept),
    .limit (half_q),
    .last  (ph_last)
  );

  // next-state logic
  always_comb begin
    state_d   = state_q;
    cs_n_d    = cs_n_q;
    sclk_d    = sclk_q;
    edge_d    = edge_q;
    half_d    = half_q;
    nbits_d   = nbits_q;
    end_d     = end_q;
    valid_d   = 1'b0;
    cap_en    = 1'b0;
    publish   = 1'b0;
    frame_clr = 1'b0;
    gap_load  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d   = ST_SETUP;
          cs_n_d    = 1'b0;
          edge_d    = '0;
          half_d    = half_eff;
          nbits_d   = nbits_eff;
          end_d     = end_eff;
          frame_clr = 1'b1;
        end
      end
      ST_SETUP, ST_LOW: begin
        if (ph_last) begin
          state_d = ST_HIGH;
          sclk_d  = 1'b1;
          edge_d  = edge_nx;
          cap_en  = (edge_nx > LEAD_E) &&
                    (edge_nx <= LEAD_E + EDGE_W'(nbits_q));
        end
      end
      ST_HIGH: begin
        if (ph_last) begin
          sclk_d = 1'b0;
          if (edge_q == end_q) begin
            state_d  = ST_IDLE;
            cs_n_d   = 1'b1;
            valid_d  = 1'b1;
            publish  = 1'b1;
            gap_load = 1'b1;
          end else begin
            state_d = ST_LOW;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE;
      cs_n_q  <= 1'b1;
      sclk_q  <= 1'b0;
      valid_q <= 1'b0;
      edge_q  <= '0;
      half_q  <= DIV_W'(1);
      nbits_q <= BCNT_W'(RES_W);
      end_q   <= FULL_E;
    end else begin
      state_q <= state_d;
      cs_n_q  <= cs_n_d;
      sclk_q  <= sclk_d;
      valid_q <= valid_d;
      edge_q  <= edge_d;
      half_q  <= half_d;
      nbits_q <= nbits_d;
      end_q   <= end_d;
    end
  end

  sar_rd_shift #(.RES_W(RES_W), .BCNT_W(BCNT_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .clr     (frame_clr),
    .cap_en  (cap_en),
    .sdi     (sdi),
    .nbits   (nbits_q),
    .publish (publish),
    .result  (result)
  );

  sar_rd_gap #(.GAP_W(GAP_W)) u_gap (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .load   (gap_load),
    .gap_in (gap_cycles),
    .ready  (gap_ready)
  );

  assign cs_n         = cs_n_q;
  assign sclk         = sclk_q;
  assign result_valid = valid_q;
  assign busy         = (state_q != ST_IDLE);

  AST_CS_FALL_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_i_n)
    $fell(cs_n) |-> !sclk); // R3
  AST_SCLK_RISE_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(sclk) |-> $past(!cs_n)); // R3
  AST_VALID_ONLY_ON_CS_RISE: assert property (@(posedge clk) disable iff (!rst_i_n)
    result_valid |-> $rose(cs_n)); // R8
  AST_CS_RISE_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(cs_n) |-> result_valid); // R8
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_i_n)
    cs_n |-> !sclk); // R11
  AST_BUSY_MATCHES_CS: assert property (@(posedge clk) disable iff (!rst_i_n)
    busy == !cs_n); // R10
  AST_START_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_i_n)
    $fell(cs_n) |-> $past(gap_ready)); // R9
  AST_EDGE_BOUND: assert property (@(posedge clk) disable iff (!rst_i_n)
    edge_q <= FULL_E); // R5
  AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_i_n)
    (busy && $past(busy)) |-> ($stable(half_q) && $stable(end_q))); // R12

endmodule

// File: tb/tb_sar_frame_reader.sv
`timescale 1ns/1ps
module tb_sar_frame_reader;

  localparam int RES_W  = 14;
  localparam int DIV_W  = 8;
  localparam int GAP_W  = 16;
  localparam int BCNT_W = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [DIV_W-1:0]  half_div = 8'd1;
  logic [BCNT_W-1:0] bit_count = 4'd14;
  logic [GAP_W-1:0]  gap_cycles = 16'd0;
  logic              sdi = 1'b0;
  logic              cs_n, sclk, result_valid, busy;
  logic [RES_W-1:0]  result;
  logic [RES_W-1:0]  conv_word = '0;

  sar_frame_reader #(.RES_W(RES_W), .DIV_W(DIV_W), .GAP_W(GAP_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .half_div(half_div),
    .bit_count(bit_count), .gap_cycles(gap_cycles), .sdi(sdi),
    .cs_n(cs_n), .sclk(sclk), .result(result),
    .result_valid(result_valid), .busy(busy)
  );

  int n_checks = 0;
  int n_fail   = 0;
  string tag = "reset";

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s [%s] t=%0t actual=%0h expected=%0h", req, tag, $time, act, exp);
    end
  endtask

  // behavioural reference model
  bit m_run = 0;
  int m_d = 0, m_h = 1, m_n = 14, m_end = 18, m_gap = 0, m_acc = 0;
  logic [RES_W-1:0] m_conv = '0;
  // converter model
  bit prev_cs = 1, prev_sclk = 0;
  int fcnt = 0;
  logic [RES_W-1:0] cv = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      bit acc, ended;
      int e_sclk;
      acc = !m_run && (m_gap == 0) && start;
      ended = 0;
      if (m_run) begin
        m_d++;
        if (m_d == 2 * m_h * m_end) begin
          m_run = 0; ended = 1; m_gap = int'(gap_cycles);
        end
      end else if (m_gap > 0) m_gap--;
      if (acc) begin
        m_run = 1; m_d = 0; m_acc++;
        m_h = (half_div == 0) ? 1 : int'(half_div);
        m_n = (bit_count == 0 || bit_count > 14) ? 14 : int'(bit_count);
        m_end = (m_n == 14) ? 18 : m_n + 2;
        m_conv = conv_word;
      end
      e_sclk = (m_run && m_d >= m_h && (((m_d - m_h) / m_h) % 2 == 0)) ? 1 : 0;
      check("R2 R5 R6 R9 cs_n", int'(cs_n), m_run ? 0 : 1);
      check("R3 R11 sclk", int'(sclk), e_sclk);
      check("R10 busy", int'(busy), m_run ? 1 : 0);
      check("R8 result_valid", int'(result_valid), ended ? 1 : 0);
      if (ended)
        check("R4 R7 result", int'(result),
              int'((m_conv >> (14 - m_n)) << (14 - m_n)));
      // converter: launches bits on falling edges of sclk (cs fall = edge 1)
      if (prev_cs && !cs_n) begin
        fcnt = 1; cv = conv_word; sdi <= 1'b0;
      end else if (!cs_n && prev_sclk && !sclk) begin
        fcnt++;
        sdi <= (fcnt >= 3 && fcnt <= 16) ? cv[16 - fcnt] : 1'b0;
      end else if (cs_n) sdi <= 1'b0;
      prev_cs = cs_n; prev_sclk = sclk;
    end
  end

  task automatic frame(input int h, input int n, input int g, input logic [RES_W-1:0] w,
                       input string t);
    @(negedge clk); #1;
    tag = t; half_div = DIV_W'(h); bit_count = BCNT_W'(n);
    gap_cycles = GAP_W'(g); conv_word = w; start = 1'b1;
    do @(negedge clk); while (!m_run);
    #1 start = 1'b0;
    while (m_run || m_gap != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 cs_n", int'(cs_n), 1);
    check("R1 sclk", int'(sclk), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 result_valid", int'(result_valid), 0);
    check("R1 result", int'(result), 0);
    #1 rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 result after release", int'(result), 0);

    frame(1, 14, 4, 14'h2A5C, "R5 full H1");
    frame(3, 14, 2, 14'h3FFF, "R5 full H3");
    frame(2, 5, 3, 14'h1555, "R6 R7 short 5");
    frame(1, 1, 0, 14'h2000, "R6 R7 short 1");
    frame(0, 0, 1, 14'h0001, "R3 R5 zero settings");
    frame(2, 15, 0, 14'h2AAA, "R5 count above 14");
    check("R8 result held", int'(result), 14'h2AAA);

    // R2 R9: start held through a frame and its gap
    @(negedge clk); #1;
    tag = "R2 R9 held start"; half_div = 8'd1; bit_count = 4'd3;
    gap_cycles = 16'd7; conv_word = 14'h3A00; start = 1'b1;
    begin
      int target;
      target = m_acc + 3;
      while (m_acc < target) @(negedge clk);
    end
    #1 start = 1'b0;
    while (m_run || m_gap != 0) @(negedge clk);

    // R12: configuration changed mid-frame
    @(negedge clk); #1;
    tag = "R12 mid-frame change"; half_div = 8'd2; bit_count = 4'd14;
    gap_cycles = 16'd2; conv_word = 14'h1234; start = 1'b1;
    do @(negedge clk); while (!m_run);
    #1 start = 1'b0;
    repeat (10) @(negedge clk);
    #1 half_div = 8'd1; bit_count = 4'd3;
    while (m_run || m_gap != 0) @(negedge clk);
    check("R12 result", int'(result), 14'h1234);
    repeat (5) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    finish_run();
  end

endmodule